// File: doc/BRIEF.md
# Shared Video Bus Isolation Controller

This block sits between a processor data bus and a separate data bus that serves video memory. It drives the active-low output enable and the direction control of the bidirectional transceiver that joins the two buses. A raster-paced generator opens short windows in which the video fetch logic owns the video bus, and the transceiver is switched off during each of them. An address decode sets the direction of the transceiver. The transceiver is also switched off whenever a cartridge or an expansion device owns the processor bus. A one-cycle flag marks the remaining hazard: an extended-ROM read inside the video window while the transceiver still drives the processor bus.

The raster runs from the pixel-rate clock. Each active line holds a fixed number of fetch groups. Each group has a burst of fetch pulses followed by an idle stretch. A run of blank lines closes the frame. All outputs are registered.

Top module: `vbus_iso_top`

## Requirements
- R1: During and right after synchronous reset, `xcvr_oe_n` is 0, `xcvr_dir` is 0 and `clash` is 0. The raster starts at line 0, position 0, with no fetch in progress.
- R2: On an active line, each group of 2*(16+12) clocks begins with 16 fetch pulses. Each pulse is one clock with the fetch active and one clock with it inactive. 24 idle clocks follow. The group repeats `GROUPS_PER_LINE` times per line. While the fetch is active, `xcvr_oe_n` is 1.
- R3: Lines 0 to 191 are active. Lines 192 to 261 carry no fetch pulse. The frame then wraps to line 0.
- R4: `xcvr_oe_n` is 1 when the fetch is active, or when `cpu_mreq_n`=0 and either `cart_sel_n`=0 or `xbus_en_n`=0. Otherwise it is 0.
- R5: `xcvr_dir` is 1 (video bus toward processor bus) exactly when `cpu_mreq_n`=0, `cpu_rd_n`=0 and 0x4000 <= `cpu_addr` <= 0x7FFF. Otherwise it is 0 (processor bus toward video bus).
- R6: `xrom_sel_n` has no effect on `xcvr_oe_n` or `xcvr_dir`.
- R7: `clash` is 1 exactly when the transceiver is enabled (`xcvr_oe_n`=0), points toward the processor bus (`xcvr_dir`=1), and `xrom_sel_n` was 0 in the sampled cycle.
- R8: Every output reflects the inputs and raster position sampled at the previous rising clock edge, so there is one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_addr | input | 16 | Processor address |
| cpu_mreq_n | input | 1 | Memory request, active low |
| cpu_rd_n | input | 1 | Read strobe, active low |
| cart_sel_n | input | 1 | Cartridge memory select, active low |
| xbus_en_n | input | 1 | Expansion-bus memory enable, active low |
| xrom_sel_n | input | 1 | Extended-ROM select, active low |
| xcvr_oe_n | output | 1 | Transceiver output enable, active low |
| xcvr_dir | output | 1 | Transceiver direction, 1 = video bus to processor bus |
| clash | output | 1 | One-cycle flag for an extended-ROM read while the transceiver drives the processor bus |

## Verification
Every result depends only on the inputs and raster position present at one rising edge, and it appears after that edge. The bench changes its inputs on the falling edge. At the next falling edge it compares all three outputs against values its own functions compute from those inputs and from its own count of edges since reset. The raster position needed for each expected value comes from that edge count, so a full idle frame is checked clock by clock as well as by pulses per line and by the number of blank lines.

// File: rtl/vbus_pkg.sv
package vbus_pkg;

  // Processor-side request, normalised to active-high flags
  typedef struct packed {
    logic mreq;
    logic rd;
    logic cart;
    logic xbus;
    logic xrom;
  } cpu_req_t;

  // Registered output bundle
  typedef struct packed {
    logic oe_n;
    logic dir;
    logic clash;
  } xcvr_ctl_t;

endpackage

// File: rtl/vbus_raster_timer.sv
module vbus_raster_timer #(
  parameter int PULSES_ON       = 16,
  parameter int PULSES_OFF      = 12,
  parameter int GROUPS_PER_LINE = 8,
  parameter int ACTIVE_LINES    = 192,
  parameter int BLANK_LINES     = 70
) (
  input  logic clk,
  input  logic rst,
  output logic fetch
);

  localparam int GROUP_LEN   = 2 * (PULSES_ON + PULSES_OFF);
  localparam int BURST_LEN   = 2 * PULSES_ON;
  localparam int TOTAL_LINES = ACTIVE_LINES + BLANK_LINES;
  localparam int PH_W   = $clog2(GROUP_LEN);
  localparam int GRP_W  = (GROUPS_PER_LINE > 1) ? $clog2(GROUPS_PER_LINE) : 1;
  localparam int LINE_W = $clog2(TOTAL_LINES);

  localparam logic [PH_W-1:0]   PH_LAST   = PH_W'(GROUP_LEN - 1);
  localparam logic [PH_W-1:0]   PH_BURST  = PH_W'(BURST_LEN);
  localparam logic [GRP_W-1:0]  GRP_LAST  = GRP_W'(GROUPS_PER_LINE - 1);
  localparam logic [LINE_W-1:0] LINE_LAST = LINE_W'(TOTAL_LINES - 1);
  localparam logic [LINE_W-1:0] LINE_ACT  = LINE_W'(ACTIVE_LINES);

  logic [PH_W-1:0]   ph_q;
  logic [GRP_W-1:0]  grp_q;
  logic [LINE_W-1:0] line_q;

  // Position inside a group, group inside a line, line inside the frame
  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q   <= '0;
      grp_q  <= '0;
      line_q <= '0;
    end else if (ph_q == PH_LAST) begin
      ph_q <= '0;
      if (grp_q == GRP_LAST) begin
        grp_q  <= '0;
        line_q <= (line_q == LINE_LAST) ? '0 : line_q + 1'b1;
      end else begin
        grp_q <= grp_q + 1'b1;
      end
    end else begin
      ph_q <= ph_q + 1'b1;
    end
  end

  // Fetch is high on the first half of each burst pulse of an active line
  always_comb begin
    fetch = (line_q < LINE_ACT) && (ph_q < PH_BURST) && !ph_q[0];
  end

  // R2
  pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
    fetch |=> !fetch);

  // R3
  line_range_chk: assert property (@(posedge clk) disable iff (rst)
    line_q <= LINE_LAST);

  // R3
  line_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (line_q == LINE_LAST && grp_q == GRP_LAST && ph_q == PH_LAST) |=> (line_q == '0));

endmodule

// File: rtl/vbus_addr_decode.sv
module vbus_addr_decode
  import vbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int WIN_LO = 'h4000,
  parameter int WIN_HI = 'h7FFF
) (
  input  logic [ADDR_W-1:0] addr,
  input  cpu_req_t          req,
  input  logic              fetch,
  output xcvr_ctl_t         nxt
);

  localparam logic [ADDR_W-1:0] LO_V = ADDR_W'(WIN_LO);
  localparam logic [ADDR_W-1:0] HI_V = ADDR_W'(WIN_HI);

  logic in_win;
  logic ext_own;

  always_comb begin
    in_win    = (addr >= LO_V) && (addr <= HI_V);
    ext_own   = req.mreq && (req.cart || req.xbus);
    nxt.oe_n  = fetch || ext_own;
    nxt.dir   = req.mreq && req.rd && in_win;
    nxt.clash = !nxt.oe_n && nxt.dir && req.xrom;
  end

endmodule

// File: rtl/vbus_iso_top.sv
module vbus_iso_top
  import vbus_pkg::*;
#(
  parameter int ADDR_W          = 16,
  parameter int WIN_LO          = 'h4000,
  parameter int WIN_HI          = 'h7FFF,
  parameter int PULSES_ON       = 16,
  parameter int PULSES_OFF      = 12,
  parameter int GROUPS_PER_LINE = 8,
  parameter int ACTIVE_LINES    = 192,
  parameter int BLANK_LINES     = 70
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_mreq_n,
  input  logic              cpu_rd_n,
  input  logic              cart_sel_n,
  input  logic              xbus_en_n,
  input  logic              xrom_sel_n,
  output logic              xcvr_oe_n,
  output logic              xcvr_dir,
  output logic              clash
);

  logic      fetch;
  cpu_req_t  req;
  xcvr_ctl_t nxt;
  xcvr_ctl_t ctl_q;

  vbus_raster_timer #(
    .PULSES_ON      (PULSES_ON),
    .PULSES_OFF     (PULSES_OFF),
    .GROUPS_PER_LINE(GROUPS_PER_LINE),
    .ACTIVE_LINES   (ACTIVE_LINES),
    .BLANK_LINES    (BLANK_LINES)
  ) i_timer (
    .clk  (clk),
    .rst  (rst),
    .fetch(fetch)
  );

  always_comb begin
    req.mreq = !cpu_mreq_n;
    req.rd   = !cpu_rd_n;
    req.cart = !cart_sel_n;
    req.xbus = !xbus_en_n;
    req.xrom = !xrom_sel_n;
  end

  vbus_addr_decode #(
    .ADDR_W(ADDR_W),
    .WIN_LO(WIN_LO),
    .WIN_HI(WIN_HI)
  ) i_decode (
    .addr (cpu_addr),
    .req  (req),
    .fetch(fetch),
    .nxt  (nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
    end else begin
      ctl_q <= nxt;
    end
  end

  assign xcvr_oe_n = ctl_q.oe_n;
  assign xcvr_dir  = ctl_q.dir;
  assign clash     = ctl_q.clash;

  // R4
  ext_own_chk: assert property (@(posedge clk) disable iff (rst)
    (!cpu_mreq_n && (!cart_sel_n || !xbus_en_n)) |=> xcvr_oe_n);

  // R5
  dir_read_chk: assert property (@(posedge clk) disable iff (rst)
    (!cpu_mreq_n && !cpu_rd_n && cpu_addr >= ADDR_W'(WIN_LO) && cpu_addr <= ADDR_W'(WIN_HI))
      |=> xcvr_dir);

  // R5
  dir_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd_n || cpu_mreq_n) |=> !xcvr_dir);

  // R7
  clash_src_chk: assert property (@(posedge clk) disable iff (rst)
    clash |-> ($past(!xrom_sel_n) && !xcvr_oe_n && xcvr_dir));

endmodule

// File: tb/test_vbus_iso_top.sv
module test_vbus_iso_top;

  localparam int ON     = 16;
  localparam int OFF    = 12;
  localparam int GROUPS = 4;
  localparam int ACT    = 192;
  localparam int BLANK  = 70;
  localparam int GLEN   = 2 * (ON + OFF);
  localparam int LLEN   = GLEN * GROUPS;
  localparam int FRAME  = LLEN * (ACT + BLANK);

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic        cpu_mreq_n = 1'b1, cpu_rd_n = 1'b1, cart_sel_n = 1'b1;
  logic        xbus_en_n = 1'b1, xrom_sel_n = 1'b1;
  logic        xcvr_oe_n, xcvr_dir, clash;

  int tests = 0;
  int fails = 0;
  int k = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  vbus_iso_top #(.GROUPS_PER_LINE(GROUPS)) i_vbus_iso_top (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_mreq_n(cpu_mreq_n),
    .cpu_rd_n(cpu_rd_n), .cart_sel_n(cart_sel_n), .xbus_en_n(xbus_en_n),
    .xrom_sel_n(xrom_sel_n), .xcvr_oe_n(xcvr_oe_n), .xcvr_dir(xcvr_dir), .clash(clash)
  );

  function automatic bit exp_fetch(int idx);
    int f = idx % FRAME;
    int ln = f / LLEN;
    int ph = (f % LLEN) % GLEN;
    return (ln < ACT) && (ph < 2 * ON) && (ph % 2 == 0);
  endfunction

  function automatic bit exp_dir();
    return !cpu_mreq_n && !cpu_rd_n && cpu_addr >= 16'h4000 && cpu_addr <= 16'h7FFF;
  endfunction

  function automatic bit exp_oe_n(int idx);
    return exp_fetch(idx) || (!cpu_mreq_n && (!cart_sel_n || !xbus_en_n));
  endfunction

  task automatic check(string tag, string what, logic got, logic exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s at step %0d: got %b expected %b", tag, what, k, got, exp);
    end
  endtask

  // One clock: inputs already set; sample after the edge and compare (R8)
  task automatic step();
    bit eo, ed, ec;
    eo = exp_oe_n(k);
    ed = exp_dir();
    ec = !eo && ed && !xrom_sel_n;
    @(negedge clk);
    check(!xrom_sel_n ? "R6" : "R4", "oe_n", xcvr_oe_n, eo);
    check("R5", "dir", xcvr_dir, ed);
    check("R7", "clash", clash, ec);
    k++;
  endtask

  task automatic set_in(logic [15:0] a, logic [4:0] c);
    cpu_addr   = a;
    cpu_mreq_n = ~c[0];
    cpu_rd_n   = ~c[1];
    cart_sel_n = ~c[2];
    xbus_en_n  = ~c[3];
    xrom_sel_n = ~c[4];
  endtask

  initial begin
    int blank_seen;
    int pulses;
    logic prev;
    logic [15:0] corners [6];
    int seed;
    corners = '{16'h0000, 16'h3FFF, 16'h4000, 16'h7FFF, 16'h8000, 16'hFFFF};
    seed = $urandom(32'd20140504);
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "oe_n", xcvr_oe_n, 1'b0);
    check("R1", "dir", xcvr_dir, 1'b0);
    check("R1", "clash", clash, 1'b0);
    rst = 1'b0;
    k = 0;

    // R2 / R3: one idle frame, checked clock by clock and per line
    blank_seen = 0;
    prev = 1'b0;
    for (int ln = 0; ln < ACT + BLANK; ln++) begin
      pulses = 0;
      for (int c = 0; c < LLEN; c++) begin
        @(negedge clk);
        check(ln < ACT ? "R2" : "R3", "raster oe_n", xcvr_oe_n, exp_fetch(k));
        if (xcvr_oe_n && !prev) pulses++;
        prev = xcvr_oe_n;
        k++;
      end
      if (pulses == 0) blank_seen++;
      tests++;
      if (pulses != ((ln < ACT) ? ON * GROUPS : 0)) begin
        fails++;
        $display("FAIL R2 pulses on line %0d: got %0d expected %0d", ln, pulses,
                 (ln < ACT) ? ON * GROUPS : 0);
      end
    end
    tests++;
    if (blank_seen != BLANK) begin
      fails++;
      $display("FAIL R3 blank lines: got %0d expected %0d", blank_seen, BLANK);
    end
    // R3: frame wraps to line 0 with a fetch pulse at position 0
    step();
    check("R3", "wrap oe_n", xcvr_oe_n, 1'b1);

    // R4 R5 R6 R7: truth table over address corners and select combinations
    for (int a = 0; a < 6; a++) begin
      for (int c = 0; c < 32; c++) begin
        if (c[2] && c[4]) continue;
        set_in(corners[a], 5'(c));
        step();
      end
    end

    // Random traffic, cartridge and extended-ROM selects kept exclusive
    for (int i = 0; i < 3000; i++) begin
      logic [4:0] c;
      logic [15:0] a;
      c = 5'($urandom);
      if (c[2] && c[4]) c[2] = 1'b0;
      a = (i % 3 == 0) ? 16'h4000 + 16'($urandom % 16'h4000) : 16'($urandom);
      set_in(a, c);
      step();
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule